// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block walks a DMA channel through memory one element at a time. It produces the byte address of each element for one-dimensional (linear) and two-dimensional (row-by-row) transfers. A transfer is set up by six values: a base address, a count of elements per row, a stride between elements within a row, a count of rows, a stride from the last element of one row to the first element of the next, and an element size. These values come either from configuration inputs that a register file drives, or from one packed descriptor word supplied on a parameter port.

While a transfer runs, the current address is shown on `addr`. Each accepted handshake on `xfer_ack` moves it to the next element. Two flags mark the current element: `row_end` for the last element of a row and `done` for the last element of the transfer. Both strides are signed and independent, and the row-change stride may be smaller than the in-row stride, even negative. With these strides one channel can pull several interleaved streams apart as it reads them. Moving the data, the bus protocol and peripheral requests are handled elsewhere.

Top module: `dma2d_agen`

## Requirements
- R1: After reset, `busy`, `row_end` and `done` are 0.
- R2: A pulse on `start_reg` while idle loads the register inputs. In the next cycle `busy` is 1 and `addr` equals `reg_base`.
- R3: A pulse on `desc_load` while idle loads the descriptor word. Its fields are: base in bits [31:0], row element count in [47:32], in-row stride in [63:48], row count in [79:64], row-change stride in [95:80], element size code in [97:96], and two-dimensional mode in bit 98. If `start_reg` and `desc_load` pulse in the same cycle, the register inputs are used.
- R4: When `xfer_ack` is accepted on an element that is not the last of its row, `addr` advances by the in-row stride times the element size.
- R5: When `xfer_ack` is accepted on the last element of a row that is not the final row, `addr` advances by the row-change stride times the element size. `row_end` is 1 exactly on the last element of each row.
- R6: A count field of 0 stands for 65536 elements or rows.
- R7: When the mode bit is 0 (one-dimensional), the row count and the row-change stride have no effect. The transfer ends after the row element count.
- R8: `done` is 1 exactly on the final element, together with `row_end`. Its acknowledge makes the block idle. Further acknowledges while idle change nothing.
- R9: Strides are two's-complement signed. Address arithmetic wraps modulo 2^32, so a row-change stride smaller than the in-row stride produces an interleaved walk.
- R10: Element size codes: 0 means 1 byte, 1 means 2 bytes, 2 and 3 mean 4 bytes.
- R11: `start_reg` and `desc_load` are ignored while `busy` is 1.
- R12: While `busy` is 1 and `xfer_ack` is 0, `addr` and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_reg | input | 1 | Start using the register inputs |
| reg_base | input | 32 | Base byte address |
| reg_xcnt | input | 16 | Elements per row (0 = 65536) |
| reg_xstep | input | 16 | Signed in-row stride in elements |
| reg_ycnt | input | 16 | Rows (0 = 65536) |
| reg_ystep | input | 16 | Signed row-change stride in elements |
| reg_esize | input | 2 | Element size code |
| reg_two_d | input | 1 | 1 = two-dimensional mode |
| desc_load | input | 1 | Start using the descriptor word |
| desc_word | input | 99 | Packed descriptor |
| xfer_ack | input | 1 | Current element accepted |
| busy | output | 1 | Transfer in progress |
| addr | output | 32 | Current element byte address |
| row_end | output | 1 | Current element ends a row |
| done | output | 1 | Current element is the last one |

## Verification
The block keeps its state in a few counters and one address register. A wrong counter reload or a wrong stride choice therefore shows up on `addr` or on the flags at the very next acknowledged element, and the error repeats for every row after it. An off-by-one in the count handling does not show until the end of a row or of the whole transfer. There `row_end` or `done` appears one element early or late, so the full-size 65536-element case and the 1-D case that carries nonzero row values are walked to completion. Interleaved, negative and wrapping strides are compared element by element against addresses the bench computes itself.

// File: rtl/dma2d_agen.sv
module dma2d_agen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STR_W  = 16,
  parameter int DESC_W = ADDR_W + 2*CNT_W + 2*STR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_reg,
  input  logic [ADDR_W-1:0] reg_base,
  input  logic [CNT_W-1:0]  reg_xcnt,
  input  logic [STR_W-1:0]  reg_xstep,
  input  logic [CNT_W-1:0]  reg_ycnt,
  input  logic [STR_W-1:0]  reg_ystep,
  input  logic [1:0]        reg_esize,
  input  logic              reg_two_d,
  input  logic              desc_load,
  input  logic [DESC_W-1:0] desc_word,
  input  logic              xfer_ack,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              row_end,
  output logic              done
);
  localparam int XC_LO = ADDR_W;
  localparam int XS_LO = XC_LO + CNT_W;
  localparam int YC_LO = XS_LO + STR_W;
  localparam int YS_LO = YC_LO + CNT_W;
  localparam int ES_LO = YS_LO + STR_W;
  localparam int MD_B  = ES_LO + 2;

  function automatic logic [ADDR_W-1:0] scale(input logic [STR_W-1:0] st, input logic [1:0] es);
    logic [ADDR_W-1:0] s;
    s = {{(ADDR_W-STR_W){st[STR_W-1]}}, st};
    case (es)
      2'd0:    scale = s;
      2'd1:    scale = s << 1;
      default: scale = s << 2;
    endcase
  endfunction

  logic [ADDR_W-1:0] ld_base;
  logic [CNT_W-1:0]  ld_xcnt, ld_ycnt;
  logic [STR_W-1:0]  ld_xstep, ld_ystep;
  logic [1:0]        ld_es;
  logic              ld_2d;

  always_comb begin
    if (start_reg) begin
      ld_base  = reg_base;
      ld_xcnt  = reg_xcnt;
      ld_xstep = reg_xstep;
      ld_ycnt  = reg_ycnt;
      ld_ystep = reg_ystep;
      ld_es    = reg_esize;
      ld_2d    = reg_two_d;
    end else begin
      ld_base  = desc_word[ADDR_W-1:0];
      ld_xcnt  = desc_word[XC_LO +: CNT_W];
      ld_xstep = desc_word[XS_LO +: STR_W];
      ld_ycnt  = desc_word[YC_LO +: CNT_W];
      ld_ystep = desc_word[YS_LO +: STR_W];
      ld_es    = desc_word[ES_LO +: 2];
      ld_2d    = desc_word[MD_B];
    end
  end

  logic              load;
  logic              step;
  logic [CNT_W-1:0]  xrem, yrem, xreload;
  logic [ADDR_W-1:0] xinc, yinc;

  assign load    = !busy && (start_reg || desc_load);
  assign step    = busy && xfer_ack;
  assign row_end = busy && (xrem == '0);
  assign done    = row_end && (yrem == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      addr    <= '0;
      xrem    <= '0;
      yrem    <= '0;
      xreload <= '0;
      xinc    <= '0;
      yinc    <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      addr    <= ld_base;
      xrem    <= ld_xcnt - 1'b1;
      xreload <= ld_xcnt - 1'b1;
      yrem    <= ld_2d ? ld_ycnt - 1'b1 : '0;
      xinc    <= scale(ld_xstep, ld_es);
      yinc    <= scale(ld_ystep, ld_es);
    end else if (step) begin
      if (xrem != '0) begin
        addr <= addr + xinc;
        xrem <= xrem - 1'b1;
      end else if (yrem != '0) begin
        addr <= addr + yinc;
        xrem <= xreload;
        yrem <= yrem - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!row_end && !done));
  p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_reg) |=> (busy && addr == $past(reg_base)));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_ack) |=> (busy && $stable(addr)));
  p_done_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> row_end);
  p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_ack && done) |=> !busy);
  p_stay_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_inrow_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_ack && !row_end) |=> (addr == $past(addr) + $past(xinc)));
endmodule

// File: tb/dma2d_agen_test.sv
module dma2d_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_reg = 1'b0;
  logic [31:0] reg_base = '0;
  logic [15:0] reg_xcnt = '0, reg_xstep = '0, reg_ycnt = '0, reg_ystep = '0;
  logic [1:0]  reg_esize = '0;
  logic        reg_two_d = 1'b0;
  logic        desc_load = 1'b0;
  logic [98:0] desc_word = '0;
  logic        xfer_ack = 1'b0;
  logic        busy, row_end, done;
  logic [31:0] addr;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dma2d_agen uut (
    .clk(clk), .rst_n(rst_n), .start_reg(start_reg), .reg_base(reg_base),
    .reg_xcnt(reg_xcnt), .reg_xstep(reg_xstep), .reg_ycnt(reg_ycnt),
    .reg_ystep(reg_ystep), .reg_esize(reg_esize), .reg_two_d(reg_two_d),
    .desc_load(desc_load), .desc_word(desc_word), .xfer_ack(xfer_ack),
    .busy(busy), .addr(addr), .row_end(row_end), .done(done));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic go_reg(input logic [31:0] b, input int nx, input int sx, input int ny,
                        input int sy, input logic [1:0] es, input logic td);
    reg_base = b; reg_xcnt = 16'(nx); reg_xstep = 16'(sx); reg_ycnt = 16'(ny);
    reg_ystep = 16'(sy); reg_esize = es; reg_two_d = td;
    start_reg = 1'b1;
    @(negedge clk);
    start_reg = 1'b0;
  endtask

  task automatic go_desc(input logic [31:0] b, input int nx, input int sx, input int ny,
                         input int sy, input logic [1:0] es, input logic td);
    desc_word = {td, es, 16'(sy), 16'(ny), 16'(sx), 16'(nx), b};
    desc_load = 1'b1;
    @(negedge clk);
    desc_load = 1'b0;
  endtask

  // Walks the whole transfer from the current element, checks every address and flag.
  task automatic walk(input string req, input logic [31:0] b, input int nx, input int sx,
                      input int ny, input int sy, input int eb);
    logic [31:0] e = b;
    int bad = 0;
    for (int r = 0; r < ny; r++) begin
      for (int c = 0; c < nx; c++) begin
        logic le = (c == nx - 1);
        logic ld = le && (r == ny - 1);
        if ((addr !== e || row_end !== le || done !== ld || busy !== 1'b1) && bad == 0)
          $display("FAIL %s: row %0d col %0d actual addr %h re %b dn %b expected %h %b %b",
                   req, r, c, addr, row_end, done, e, le, ld);
        if (addr !== e || row_end !== le || done !== ld || busy !== 1'b1) bad++;
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        e = e + (le ? 32'(sy * eb) : 32'(sx * eb));
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
    check({req, " idle after final ack"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 row_end", {31'd0, row_end}, 0);
    check("R1 done", {31'd0, done}, 0);
  endtask

  task automatic t_basic();
    go_reg(32'h1000, 3, 4, 2, 8, 2'd0, 1'b1);
    check("R2 busy after start", {31'd0, busy}, 1);
    check("R2 base", addr, 32'h1000);
    walk("R4 R5 basic 2-D", 32'h1000, 3, 4, 2, 8, 1);
  endtask

  task automatic t_interleave();
    go_reg(32'h2000, 4, 2, 2, -5, 2'd1, 1'b1);
    walk("R9 interleave", 32'h2000, 4, 2, 2, -5, 2);
  endtask

  task automatic t_desc();
    go_desc(32'h8000_0000, 2, 3, 3, -1, 2'd2, 1'b1);
    check("R3 desc base", addr, 32'h8000_0000);
    walk("R3 R10 descriptor", 32'h8000_0000, 2, 3, 3, -1, 4);
    desc_word = {1'b0, 2'd0, 16'd0, 16'd0, 16'd1, 16'd5, 32'hDEAD_0000};
    desc_load = 1'b1;
    go_reg(32'h0000_0300, 2, 1, 1, 0, 2'd0, 1'b0);
    desc_load = 1'b0;
    check("R3 register wins", addr, 32'h0000_0300);
    walk("R3 register wins walk", 32'h300, 2, 1, 1, 0, 1);
  endtask

  task automatic t_1d();
    go_reg(32'h40, 5, 1, 7, 100, 2'd1, 1'b0);
    walk("R7 1-D ignores row values", 32'h40, 5, 1, 1, 0, 2);
  endtask

  task automatic t_hold_ignore();
    go_reg(32'h500, 3, 1, 1, 0, 2'd3, 1'b0);
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check("R12 hold addr", addr, 32'h504);
    check("R12 hold busy", {31'd0, busy}, 1);
    go_reg(32'h9999, 8, 8, 8, 8, 2'd0, 1'b1);
    check("R11 start ignored", addr, 32'h504);
    go_desc(32'h7777, 8, 8, 8, 8, 2'd0, 1'b1);
    check("R11 desc ignored", addr, 32'h504);
    walk("R10 R11 rest of walk", 32'h504, 2, 1, 1, 0, 4);
  endtask

  task automatic t_after_done();
    xfer_ack = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    xfer_ack = 1'b0;
    check("R8 idle acks busy", {31'd0, busy}, 0);
    check("R8 idle acks done", {31'd0, done}, 0);
  endtask

  task automatic t_wrap();
    go_reg(32'h2, 2, -1, 1, 0, 2'd2, 1'b0);
    walk("R9 negative wrap", 32'h2, 2, -1, 1, 0, 4);
  endtask

  task automatic t_big();
    go_reg(32'h1_0000, 0, 1, 0, 0, 2'd0, 1'b0);
    walk("R6 count 0 is 65536", 32'h1_0000, 65536, 1, 1, 0, 1);
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_interleave();
    t_desc();
    t_1d();
    t_hold_ignore();
    t_after_done();
    t_wrap();
    t_big();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule